// File: doc/BRIEF.md
# Vertex Attribute Router and Swizzler

This block sits between a stream of vertex component words and a vertex input register file. A small table, loaded through a register-write port while the block is idle, describes each attribute of a vertex. The table has up to eight entries. Each entry has a routing word and a swizzle word. The routing word says how many 32-bit components the attribute carries and which destination register receives it. The swizzle word says which source component, or which constant, lands in each of the four output lanes, and which lanes are written.

Attributes are consumed strictly in table order. The first entry serves the first attribute of a vertex, the second entry the second attribute, and so on. The walk ends after an entry flagged as last, or after the final entry. The router then returns to entry 0 for the next vertex. Components pass through unchanged as 32-bit floats, and no format conversion is done.

A three-state machine controls the block:
- ST_IDLE accepts table writes and waits for input. It leaves on `in_valid` (idle-to-collect).
- ST_COLLECT accepts the component words of one attribute. It leaves when the last word arrives (collect-to-emit).
- ST_EMIT drives one register-file write. From there it either moves to the next entry (emit-to-collect) or ends the vertex (emit-to-idle).

Top module: `vattr_router`

## Requirements
- R1: After reset, `rf_we` and `in_ready` are 0, `cfg_ready` is 1, and the walk starts at entry 0.
- R2: Routing word bits [1:0] hold a count code. Codes 0, 1, 2 and 3 make the router accept exactly 1, 2, 3 and 4 component words for that attribute. The words are stored as source components X, Y, Z and W in arrival order.
- R3: Routing word bits [12:8] give the destination index, which appears on `rf_idx` during the write.
- R4: Routing word bit 13 marks the last entry. After that entry's write, the router is idle (`cfg_ready`=1, `in_ready`=0), and the next vertex restarts at entry 0.
- R5: Entries are used in order. The n-th write of a vertex uses entry n-1.
- R6: Swizzle word bits [2:0], [5:3], [8:6] and [11:9] select the X, Y, Z and W output lanes. Lane X is `rf_data[31:0]` and lane W is `rf_data[127:96]`. Codes 0 to 3 pick source component X, Y, Z or W.
- R7: Selector code 4 yields 0x00000000, and code 5 yields 0x3F800000 (1.0).
- R8: A selector naming a component beyond the attribute's count yields 0. Codes 6 and 7 also yield 0.
- R9: Swizzle word bits [15:12] appear on `rf_lane_en` (bit 0 = lane X) during the write.
- R10: Table writes complete only while idle. `cfg_ready` is 0 whenever the router is collecting or emitting, and a write is held until the router is idle.
- R11: If no entry before the final one carries the last flag, the walk stops after the final entry (entry 7 by default) and the router goes idle.
- R12: `rf_we` is a one-cycle pulse. It is raised in the cycle after the edge that accepts an attribute's final component word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Table write request |
| cfg_ready | output | 1 | Table write accepted this cycle (idle only) |
| cfg_sel | input | 1 | 0 = routing word, 1 = swizzle word |
| cfg_addr | input | 3 | Table entry number |
| cfg_data | input | 16 | Word to store |
| in_valid | input | 1 | Component word valid |
| in_ready | output | 1 | Component word accepted this cycle |
| in_data | input | 32 | Component word |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 5 | Destination register index |
| rf_data | output | 128 | Four-lane vector, lane X in bits [31:0] |
| rf_lane_en | output | 4 | Per-lane write enables |

## Verification
Once the last component word of an attribute is accepted at a clock edge, the write for that attribute is due in the following cycle. The bench therefore samples `rf_we` at the falling edge right after that accepting edge. A monitor records every write at falling edges, so index, data and lane enables are compared against the bench model without depending on the exact gap between attributes. The idle state after a vertex is due one cycle after the last write, and the bench checks `cfg_ready`/`in_ready` at the next falling edge. Table writes land at the accepting edge and are only exercised while idle.

// File: rtl/vattr_pkg.sv
package vattr_pkg;

    // Width of one stored table word.
    localparam int CFG_W   = 16;
    // Width of one component word.
    localparam int COMP_W  = 32;
    // Number of output lanes.
    localparam int LANES   = 4;
    // Width of one lane selector.
    localparam int SEL_W   = 3;
    // Width of the destination index.
    localparam int IDX_W   = 5;

    // Routing word field positions.
    localparam int RT_CNT_LSB  = 0;
    localparam int RT_DST_LSB  = 8;
    localparam int RT_LAST_BIT = 13;

    // Swizzle word field positions.
    localparam int SW_EN_LSB = 12;

    // Constant 1.0 in IEEE-754 single precision.
    localparam logic [COMP_W-1:0] F32_ONE = 32'h3F80_0000;

    // Selector codes.
    localparam logic [SEL_W-1:0] SEL_ZERO = 3'd4;
    localparam logic [SEL_W-1:0] SEL_ONE  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_EMIT    = 2'd2
    } walk_state_t;

    typedef struct packed {
        logic             last;
        logic [IDX_W-1:0] dest;
        logic [1:0]       cnt_code;
    } route_t;

endpackage

// File: rtl/vattr_cfg_table.sv
module vattr_cfg_table
    import vattr_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [ENT_W-1:0] wr_addr,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [ENT_W-1:0] rd_addr,
    output route_t           route_o,
    output logic [CFG_W-1:0] swz_o
);

    route_t           route_q [N_ENT];
    logic [CFG_W-1:0] swz_q   [N_ENT];
    route_t           route_in;

    // Pick the used fields out of an incoming routing word.
    always_comb begin
        route_in.cnt_code = wr_data[RT_CNT_LSB +: 2];
        route_in.dest     = wr_data[RT_DST_LSB +: IDX_W];
        route_in.last     = wr_data[RT_LAST_BIT];
    end

    wire unused_rt_bits = ^{wr_data[7:2], wr_data[15:14]};

    // Generate one storage slot per table entry.
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_q[e] <= '0;
                swz_q[e]   <= '0;
            end else if (wr_en && (wr_addr == ENT_W'(e))) begin
                if (wr_sel) begin
                    swz_q[e] <= wr_data;
                end else begin
                    route_q[e] <= route_in;
                end
            end
        end
    end

    assign route_o = route_q[rd_addr];
    assign swz_o   = swz_q[rd_addr];

endmodule

// File: rtl/vattr_comp_buf.sv
module vattr_comp_buf
    import vattr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        store,
    input  logic [1:0]                  slot,
    input  logic [COMP_W-1:0]           data,
    output logic [LANES-1:0][COMP_W-1:0] comps_o
);

    // Generate one holding register per source component.
    for (genvar s = 0; s < LANES; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                comps_o[s] <= '0;
            end else if (store && (slot == 2'(s))) begin
                comps_o[s] <= data;
            end
        end
    end

endmodule

// File: rtl/vattr_lane_sel.sv
module vattr_lane_sel
    import vattr_pkg::*;
(
    input  logic [SEL_W-1:0]             sel,
    input  logic [1:0]                   cnt_code,
    input  logic [LANES-1:0][COMP_W-1:0] comps,
    output logic [COMP_W-1:0]            lane_o
);

    logic in_range;

    // A source component exists only if its number is within the count.
    assign in_range = (sel[1:0] <= cnt_code);

    always_comb begin
        lane_o = '0;
        if (!sel[2]) begin
            if (in_range) begin
                lane_o = comps[sel[1:0]];
            end
        end else if (sel == SEL_ONE) begin
            lane_o = F32_ONE;
        end else begin
            lane_o = '0;
        end
    end

endmodule

// File: rtl/vattr_router.sv
module vattr_router
    import vattr_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_valid,
    output logic                    cfg_ready,
    input  logic                    cfg_sel,
    input  logic [ENT_W-1:0]        cfg_addr,
    input  logic [CFG_W-1:0]        cfg_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [COMP_W-1:0]       in_data,
    output logic                    rf_we,
    output logic [IDX_W-1:0]        rf_idx,
    output logic [LANES*COMP_W-1:0] rf_data,
    output logic [LANES-1:0]        rf_lane_en
);

    localparam logic [ENT_W-1:0] ENT_LAST = ENT_W'(N_ENT - 1);
    localparam logic [ENT_W-1:0] ENT_ONE  = ENT_W'(1);

    walk_state_t state_q, state_d;
    logic [ENT_W-1:0] entry_q, entry_d;
    logic [1:0]       comp_q, comp_d;

    route_t                      cur_route;
    logic [CFG_W-1:0]            cur_swz;
    logic                        cur_last;
    logic                        accept;
    logic                        cfg_wr;
    logic [LANES-1:0][COMP_W-1:0] comps;

    assign cur_last = cur_route.last;
    assign accept   = in_valid && in_ready;
    assign cfg_wr   = cfg_valid && cfg_ready;

    vattr_cfg_table #(.N_ENT(N_ENT)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .rd_addr (entry_q),
        .route_o (cur_route),
        .swz_o   (cur_swz)
    );

    vattr_comp_buf u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .store   (accept),
        .slot    (comp_q),
        .data    (in_data),
        .comps_o (comps)
    );

    // Generate one selector per output lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        vattr_lane_sel u_sel (
            .sel      (cur_swz[l*SEL_W +: SEL_W]),
            .cnt_code (cur_route.cnt_code),
            .comps    (comps),
            .lane_o   (rf_data[l*COMP_W +: COMP_W])
        );
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            entry_q <= '0;
            comp_q  <= '0;
        end else begin
            state_q <= state_d;
            entry_q <= entry_d;
            comp_q  <= comp_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        entry_d = entry_q;
        comp_d  = comp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    state_d = ST_COLLECT;
                    comp_d  = '0;
                end
            end
            ST_COLLECT: begin
                if (accept) begin
                    if (comp_q == cur_route.cnt_code) begin
                        state_d = ST_EMIT;
                    end else begin
                        comp_d = comp_q + 2'd1;
                    end
                end
            end
            ST_EMIT: begin
                comp_d = '0;
                if (cur_last || (entry_q == ENT_LAST)) begin
                    state_d = ST_IDLE;
                    entry_d = '0;
                end else begin
                    state_d = ST_COLLECT;
                    entry_d = entry_q + ENT_ONE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                entry_d = '0;
                comp_d  = '0;
            end
        endcase
    end

    // Output logic.
    always_comb begin
        cfg_ready  = 1'b0;
        in_ready   = 1'b0;
        rf_we      = 1'b0;
        rf_idx     = cur_route.dest;
        rf_lane_en = cur_swz[SW_EN_LSB +: LANES];
        unique case (state_q)
            ST_IDLE:    cfg_ready = 1'b1;
            ST_COLLECT: in_ready  = 1'b1;
            ST_EMIT:    rf_we     = 1'b1;
            default:    cfg_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/vattr_router_sva.sv
module vattr_router_sva #(
    parameter int N_ENT = 8,
    localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             cfg_ready,
    input logic             rf_we,
    input logic             cur_last,
    input logic [ENT_W-1:0] entry_q
);

    // R12: the write strobe never lasts two cycles.
    a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

    // R12: a write follows the acceptance of a component word.
    a_r12_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(in_valid && in_ready));

    // R10: table port closed while words are being taken.
    a_r10_cfg_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !cfg_ready);

    // R4: after the last-flagged entry the router is idle.
    a_r4_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && cur_last) |=> (cfg_ready && !in_ready));

    // R11: after the final entry the router is idle.
    a_r11_wrap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && (entry_q == ENT_W'(N_ENT - 1))) |=> cfg_ready);

    // R1: out of reset the table port is open.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cfg_ready && !rf_we && !in_ready));

endmodule

bind vattr_router vattr_router_sva #(.N_ENT(N_ENT)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cfg_ready (cfg_ready),
    .rf_we     (rf_we),
    .cur_last  (cur_last),
    .entry_q   (entry_q)
);

// File: tb/vattr_router_tb.sv
`timescale 1ns/1ps
module vattr_router_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_valid = 1'b0;
    logic         cfg_ready;
    logic         cfg_sel = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [15:0]  cfg_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         rf_we;
    logic [4:0]   rf_idx;
    logic [127:0] rf_data;
    logic [3:0]   rf_lane_en;

    int n_chk = 0;
    int n_err = 0;

    // Bench copy of the table.
    logic [15:0] rt_m [8];
    logic [15:0] sw_m [8];

    // Expected and captured writes.
    logic [4:0]   exp_idx [8];
    logic [127:0] exp_dat [8];
    logic [3:0]   exp_en  [8];
    logic [2:0]   exp_cnt [8];
    logic [15:0]  exp_sw  [8];
    int           exp_n;
    logic [4:0]   cap_idx [16];
    logic [127:0] cap_dat [16];
    logic [3:0]   cap_en  [16];
    int           cap_n = 0;

    always #2 clk = ~clk;

    vattr_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .rf_we(rf_we), .rf_idx(rf_idx), .rf_data(rf_data), .rf_lane_en(rf_lane_en)
    );

    always @(negedge clk) begin
        if (rst_n && rf_we && cap_n < 16) begin
            cap_idx[cap_n] = rf_idx;
            cap_dat[cap_n] = rf_data;
            cap_en[cap_n]  = rf_lane_en;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_exp(input logic [2:0] code, input int cnt,
                                             input logic [31:0] c [4]);
        if (code < 3'd4) return (int'(code) < cnt) ? c[code[1:0]] : 32'h0;
        if (code == 3'd5) return 32'h3F80_0000;
        return 32'h0;
    endfunction

    function automatic string lane_req(input logic [2:0] code, input int cnt);
        if (code < 3'd4 && int'(code) < cnt) return "R6";
        if (code == 3'd4 || code == 3'd5) return "R7";
        return "R8";
    endfunction

    function automatic logic [15:0] mk_route(input int cnt, input logic [4:0] idx,
                                             input bit last);
        return {2'b00, last, idx, 6'b0, 2'(cnt - 1)};
    endfunction

    task automatic cfg_write(input bit sel, input int addr, input logic [15:0] d);
        cfg_valid = 1'b1; cfg_sel = sel; cfg_addr = 3'(addr); cfg_data = d;
        while (!cfg_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic load_table();
        for (int e = 0; e < 8; e++) begin
            cfg_write(1'b0, e, rt_m[e]);
            cfg_write(1'b1, e, sw_m[e]);
        end
    endtask

    task automatic send_word(input logic [31:0] w, input bit mid);
        in_valid = 1'b1; in_data = w;
        while (!in_ready) @(negedge clk);
        if (mid) chk(cfg_ready == 1'b0, "R10", "cfg_ready while collecting",
                     128'(cfg_ready), 128'd0);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_vertex();
        int e;
        logic [31:0] c [4];
        int cnt;
        e = 0; exp_n = 0; cap_n = 0;
        forever begin
            cnt = int'(rt_m[e][1:0]) + 1;
            for (int k = 0; k < 4; k++) c[k] = 32'h0;
            for (int k = 0; k < cnt; k++) begin
                c[k] = $urandom;
                send_word(c[k], k > 0);
            end
            chk(rf_we == 1'b1, "R12", "write strobe after last word", 128'(rf_we), 128'd1);
            exp_idx[exp_n] = rt_m[e][12:8];
            exp_en[exp_n]  = sw_m[e][15:12];
            exp_cnt[exp_n] = 3'(cnt);
            exp_sw[exp_n]  = sw_m[e];
            for (int l = 0; l < 4; l++)
                exp_dat[exp_n][l*32 +: 32] = lane_exp(sw_m[e][l*3 +: 3], cnt, c);
            exp_n++;
            if (rt_m[e][13] || e == 7) break;
            e++;
        end
        in_valid = 1'b0;
        @(negedge clk);
        chk(rf_we == 1'b0, "R12", "strobe is one cycle", 128'(rf_we), 128'd0);
        chk(cfg_ready == 1'b1 && in_ready == 1'b0, (e == 7 && !rt_m[7][13]) ? "R11" : "R4",
            "idle after vertex", 128'({cfg_ready, in_ready}), 128'(2'b10));
        chk(cap_n == exp_n, "R5", "write count", 128'(cap_n), 128'(exp_n));
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_idx[i] == exp_idx[i], "R3", "destination index",
                128'(cap_idx[i]), 128'(exp_idx[i]));
            chk(cap_en[i] == exp_en[i], "R9", "lane enables",
                128'(cap_en[i]), 128'(exp_en[i]));
            for (int l = 0; l < 4; l++)
                chk(cap_dat[i][l*32 +: 32] == exp_dat[i][l*32 +: 32],
                    lane_req(exp_sw[i][l*3 +: 3], int'(exp_cnt[i])), "lane value",
                    128'(cap_dat[i][l*32 +: 32]), 128'(exp_dat[i][l*32 +: 32]));
        end
    endtask

    function automatic logic [15:0] mk_swz(input logic [3:0] en, input logic [2:0] x,
                                           input logic [2:0] y, input logic [2:0] z,
                                           input logic [2:0] w);
        return {en, w, z, y, x};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R12 watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        chk(rf_we == 1'b0 && in_ready == 1'b0 && cfg_ready == 1'b1, "R1", "reset outputs",
            128'({rf_we, in_ready, cfg_ready}), 128'(3'b001));
        rst_n = 1'b1;
        @(negedge clk);
        chk(rf_we == 1'b0 && in_ready == 1'b0 && cfg_ready == 1'b1, "R1", "idle after reset",
            128'({rf_we, in_ready, cfg_ready}), 128'(3'b001));

        // R2/R6: four components reversed, then two components with constants.
        for (int e = 0; e < 8; e++) begin rt_m[e] = 16'h0; sw_m[e] = 16'h0; end
        rt_m[0] = mk_route(4, 5'd5, 1'b0);
        sw_m[0] = mk_swz(4'hF, 3'd3, 3'd2, 3'd1, 3'd0);
        rt_m[1] = mk_route(2, 5'd17, 1'b1);
        sw_m[1] = mk_swz(4'h3, 3'd0, 3'd1, 3'd4, 3'd5);
        rt_m[2] = mk_route(3, 5'd9, 1'b0);
        sw_m[2] = mk_swz(4'h1, 3'd2, 3'd2, 3'd2, 3'd2);
        load_table();
        run_vertex();
        run_vertex(); // R5: restart at entry 0

        // R8: selectors past the count and codes 6, 7.
        rt_m[0] = mk_route(1, 5'd31, 1'b1);
        sw_m[0] = mk_swz(4'hA, 3'd1, 3'd3, 3'd6, 3'd7);
        load_table();
        run_vertex();

        // R11: no last flag anywhere, eight attributes.
        for (int e = 0; e < 8; e++) begin
            rt_m[e] = mk_route(e % 4 + 1, 5'(e * 3), 1'b0);
            sw_m[e] = mk_swz(4'(e + 3), 3'(e % 6), 3'((e + 1) % 8), 3'd5, 3'd0);
        end
        load_table();
        run_vertex();
        run_vertex();

        // Random tables.
        for (int v = 0; v < 20; v++) begin
            int nent;
            nent = $urandom_range(1, 8);
            for (int e = 0; e < 8; e++) begin
                if (e < nent) begin
                    rt_m[e] = mk_route($urandom_range(1, 4), 5'($urandom),
                                       (e == nent - 1) && (nent < 8 || $urandom_range(0, 1) == 1));
                    sw_m[e] = 16'($urandom);
                end else begin
                    rt_m[e] = 16'($urandom) & 16'hDF03;
                    sw_m[e] = 16'h0;
                end
            end
            load_table();
            run_vertex();
            if ($urandom_range(0, 1) == 1) run_vertex();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule